// File: doc/BRIEF.md
# Memory Test Access Port Controller

This block is the serial test port of a memory device. A tester drives a test clock, a mode-select line and a serial data input, and reads a serial data output. A sixteen-state controller steps through the usual capture, shift and update phases. Each scan either goes through a 3-bit instruction register or through one of three data registers that the current instruction selects: a single bypass stage, a 32-bit identification word, or a 69-cell observe-only boundary chain. The boundary chain samples a parallel vector of device pin values.

The boundary chain has no update or drive stage, so every instruction that selects it only observes. One instruction samples the pins and also asks the device to float its data outputs. The block raises a dedicated request output for that case. Serial output changes on the falling test-clock edge. An enable output marks the cycles in which that output carries data.

Top module: `bscan_tap`

## Requirements
- R1: While the active-low power-on reset `por_n` is low, the controller is in Test-Logic-Reset, the instruction is IDCODE (001), `tdo_en` is 0, `tdo` is 0 and `io_float` is 0. Reset release is synchronised to the rising edge of `tck`.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R3: In Test-Logic-Reset the current instruction becomes IDCODE, so a data scan taken straight after reset returns the identification word.
- R4: Capture-IR loads 001 into the instruction shift stage. Shifted out least significant bit first, this gives 1, 0, 0.
- R5: Opcodes 000, 010 and 100 select the boundary chain, 001 selects the identification word, and 111 and every other code (011, 101, 110) select the bypass stage. A new opcode takes effect on the rising edge that leaves Update-IR.
- R6: The identification word is 32'h2A226069. From MSB to LSB it holds version 001, device type 01010001000100110, manufacturer 00000110100 and a presence bit of 1.
- R7: The bypass stage captures 0 in Capture-DR and delays data by one stage during Shift-DR.
- R8: The boundary chain has 69 cells. Cell 0 leaves first on `tdo`, and cell k captures `pin_vec[k]`. Cell 68 takes `tdi`. Cell 50 captures 0 whatever the value of `pin_vec[50]`.
- R9: The boundary chain is observe-only. Data shifted in never reaches the next capture, and the chain holds its contents outside Capture-DR and Shift-DR.
- R10: `io_float` is 1 exactly while the current instruction is 010. It changes only on the edge that leaves Update-IR, or at reset.
- R11: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is 1 only in Shift-DR and Shift-IR, and `tdo` is 0 whenever `tdo_en` is 0.
- R12: During a shift, `tdi` enters at the end of the selected register farthest from `tdo`, and bits leave least significant first. A scan longer than the register returns the captured value and then the bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_vec | input | 69 | Device pin values observed by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| io_float | output | 1 | Request to float the device data outputs |

## Verification
Several properties are checked on every edge: the five-high mode-select return to reset, the fixed capture values of the instruction, bypass and identification registers, the boundary chain holding still outside its capture and shift states, `io_float` rising only after Update-IR, and the enable matching the shift states. The bench scenarios are needed for the rest. These are the full opcode decode including the unlisted codes, the identification word and boundary bit order as seen at `tdo`, the constant internal cell, the falling-edge timing of `tdo`, and the fact that shifted-in boundary data never reaches a later capture.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    S_TLR    = 4'h0,
    S_RTI    = 4'h1,
    S_SEL_DR = 4'h2,
    S_CAP_DR = 4'h3,
    S_SH_DR  = 4'h4,
    S_EX1_DR = 4'h5,
    S_PAU_DR = 4'h6,
    S_EX2_DR = 4'h7,
    S_UPD_DR = 4'h8,
    S_SEL_IR = 4'h9,
    S_CAP_IR = 4'hA,
    S_SH_IR  = 4'hB,
    S_EX1_IR = 4'hC,
    S_PAU_IR = 4'hD,
    S_EX2_IR = 4'hE,
    S_UPD_IR = 4'hF
  } tap_state_e;

  localparam int unsigned IR_W = 3;
  typedef logic [IR_W-1:0] opcode_t;

  localparam opcode_t OP_EXTEST      = 3'b000;
  localparam opcode_t OP_IDCODE      = 3'b001;
  localparam opcode_t OP_SAMPLE_FLT  = 3'b010;
  localparam opcode_t OP_SAMPLE_PRE  = 3'b100;
  localparam opcode_t OP_BYPASS      = 3'b111;
  localparam opcode_t IR_CAPTURE_VAL = 3'b001;

  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_IDR = 2'd1,
    SEL_BSR = 2'd2
  } dr_sel_e;

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e st
);

  tap_state_e st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_TLR:    st_nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    st_nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: st_nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: st_nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  st_nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: st_nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: st_nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: st_nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: st_nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: st_nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: st_nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  st_nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: st_nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: st_nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: st_nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: st_nxt = tms ? S_SEL_DR : S_RTI;
      default:  st_nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= S_TLR;
    else        st <= st_nxt;
  end

  // Run-length counter of tms-high edges, saturating at five
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              hi_run <= 3'd0;
    else if (!tms)           hi_run <= 3'd0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_run == 3'd5) |-> (st == S_TLR));

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e st,
  input  logic       tdi,
  output logic       ir_lsb,
  output dr_sel_e    dr_sel,
  output logic       float_req
);

  opcode_t ir_sh, ir_sh_nxt;
  opcode_t ir_cur, ir_cur_nxt;
  logic    sh_en, cur_en;

  assign sh_en  = (st == S_CAP_IR) || (st == S_SH_IR);
  assign cur_en = (st == S_UPD_IR) || (st == S_TLR);

  always_comb begin
    ir_sh_nxt = ir_sh;
    if (st == S_CAP_IR)     ir_sh_nxt = IR_CAPTURE_VAL;
    else if (st == S_SH_IR) ir_sh_nxt = {tdi, ir_sh[IR_W-1:1]};
  end

  always_comb begin
    ir_cur_nxt = ir_cur;
    if (st == S_TLR)         ir_cur_nxt = OP_IDCODE;
    else if (st == S_UPD_IR) ir_cur_nxt = ir_sh;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sh <= OP_IDCODE;
    else if (sh_en) ir_sh <= ir_sh_nxt;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      ir_cur <= OP_IDCODE;
    else if (cur_en) ir_cur <= ir_cur_nxt;
  end

  always_comb begin
    unique case (ir_cur)
      OP_EXTEST, OP_SAMPLE_FLT, OP_SAMPLE_PRE: dr_sel = SEL_BSR;
      OP_IDCODE:                               dr_sel = SEL_IDR;
      default:                                 dr_sel = SEL_BYP;
    endcase
  end

  assign float_req = (ir_cur == OP_SAMPLE_FLT);
  assign ir_lsb    = ir_sh[0];

  a_r4_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_CAP_IR) |=> (ir_sh == 3'b001));

  a_r3_reset_selects_id: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_TLR) |=> (dr_sel == SEL_IDR));

  a_r10_float_after_update: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(float_req) |-> $past(st == S_UPD_IR));

endmodule

// File: rtl/bscan_dr.sv
module bscan_dr
  import bscan_pkg::*;
#(
  parameter int unsigned BSR_LEN  = 69,
  parameter int unsigned INT_CELL = 50,
  parameter logic        INT_VAL  = 1'b0,
  parameter logic [2:0]  ID_VER   = 3'b001,
  parameter logic [16:0] ID_PART  = 17'b01010001000100110,
  parameter logic [10:0] ID_MFR   = 11'b00000110100
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         st,
  input  dr_sel_e            dr_sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins,
  output logic               dr_lsb
);

  localparam int unsigned ID_W = $bits(ID_VER) + $bits(ID_PART) + $bits(ID_MFR) + 1;
  localparam logic [ID_W-1:0] ID_VAL = {ID_VER, ID_PART, ID_MFR, 1'b1};

  logic cap, shf;
  assign cap = (st == S_CAP_DR);
  assign shf = (st == S_SH_DR);

  // Boundary capture vector: one observe-only cell per pin, one internal cell
  logic [BSR_LEN-1:0] cap_vec;
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i == INT_CELL) begin : g_int
      assign cap_vec[i] = INT_VAL | (pins[i] & 1'b0);
    end else begin : g_pin
      assign cap_vec[i] = pins[i];
    end
  end

  // Bypass stage
  logic byp_q, byp_nxt, byp_en;
  assign byp_en  = (dr_sel == SEL_BYP) && (cap || shf);
  assign byp_nxt = cap ? 1'b0 : tdi;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_nxt;
  end

  // Identification register
  logic [ID_W-1:0] idr_q, idr_nxt;
  logic            idr_en;
  assign idr_en  = (dr_sel == SEL_IDR) && (cap || shf);
  assign idr_nxt = cap ? ID_VAL : {tdi, idr_q[ID_W-1:1]};
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      idr_q <= ID_VAL;
    else if (idr_en) idr_q <= idr_nxt;
  end

  // Boundary chain
  logic [BSR_LEN-1:0] bsr_q, bsr_nxt;
  logic               bsr_en;
  assign bsr_en  = (dr_sel == SEL_BSR) && (cap || shf);
  assign bsr_nxt = cap ? cap_vec : {tdi, bsr_q[BSR_LEN-1:1]};
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      bsr_q <= '0;
    else if (bsr_en) bsr_q <= bsr_nxt;
  end

  always_comb begin
    unique case (dr_sel)
      SEL_IDR: dr_lsb = idr_q[0];
      SEL_BSR: dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q;
    endcase
  end

  a_r7_bypass_captures_zero: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && dr_sel == SEL_BYP) |=> (byp_q == 1'b0));

  a_r6_id_capture_value: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && dr_sel == SEL_IDR) |=> (idr_q == ID_VAL));

  a_r9_chain_holds: assert property (@(posedge tck) disable iff (!rst_n)
    !(cap || shf) |=> $stable(bsr_q));

  a_r8_internal_cell_const: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && dr_sel == SEL_BSR) |=> (bsr_q[INT_CELL] == INT_VAL));

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int unsigned BSR_LEN  = 69,
  parameter int unsigned INT_CELL = 50
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_vec,
  output logic               tdo,
  output logic               tdo_en,
  output logic               io_float
);

  // Asynchronous assert, synchronous release
  logic rst_meta, rst_n;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  tap_state_e st;
  dr_sel_e    dr_sel;
  logic       ir_lsb, dr_lsb;

  bscan_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .st    (st)
  );

  bscan_ir u_ir (
    .tck       (tck),
    .rst_n     (rst_n),
    .st        (st),
    .tdi       (tdi),
    .ir_lsb    (ir_lsb),
    .dr_sel    (dr_sel),
    .float_req (io_float)
  );

  bscan_dr #(
    .BSR_LEN  (BSR_LEN),
    .INT_CELL (INT_CELL)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .st     (st),
    .dr_sel (dr_sel),
    .tdi    (tdi),
    .pins   (pin_vec),
    .dr_lsb (dr_lsb)
  );

  logic in_shift, ser_bit, tdo_nxt;
  assign in_shift = (st == S_SH_DR) || (st == S_SH_IR);
  assign ser_bit  = (st == S_SH_IR) ? ir_lsb : dr_lsb;
  assign tdo_nxt  = in_shift & ser_bit;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_en <= in_shift;
    end
  end

  a_r11_enable_tracks_shift: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == ((st == S_SH_DR) || (st == S_SH_IR)));

  a_r11_quiet_when_idle: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_en |-> !tdo);

endmodule

// File: tb/bscan_tap_tb_top.sv
module bscan_tap_tb_top;

  localparam int    TCK_PERIOD = 100;
  localparam int    BL         = 69;
  localparam int    IC         = 50;
  localparam logic [31:0] ID_EXP = 32'h2A226069;
  localparam int    SCAN_N     = 80;

  logic          tck = 1'b0;
  logic          por_n, tms, tdi;
  logic [BL-1:0] pins;
  logic          tdo, tdo_en, io_float;

  int n_chk = 0;
  int n_bad = 0;
  logic last_tdo;
  bit   finished = 1'b0;

  always #(TCK_PERIOD/2) tck = ~tck;

  bscan_tap dut_i (
    .tck      (tck),
    .por_n    (por_n),
    .tms      (tms),
    .tdi      (tdi),
    .pin_vec  (pins),
    .tdo      (tdo),
    .tdo_en   (tdo_en),
    .io_float (io_float)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
    last_tdo = tdo;
  endtask

  task automatic tms_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = last_tdo;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < SCAN_N; i++) begin
      dout[i] = last_tdo;
      step(i == SCAN_N-1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [127:0] exp_scan(input logic [2:0] op, input logic [BL-1:0] pv,
                                            input logic [127:0] din);
    logic [127:0] cv;
    int len;
    cv = '0;
    case (op)
      3'b000, 3'b010, 3'b100: begin
        len = BL;
        cv[BL-1:0] = pv;
        cv[IC] = 1'b0;
      end
      3'b001:  begin len = 32; cv[31:0] = ID_EXP; end
      default: begin len = 1;  cv[0] = 1'b0; end
    endcase
    exp_scan = '0;
    for (int i = 0; i < SCAN_N; i++)
      exp_scan[i] = (i < len) ? cv[i] : din[i-len];
  endfunction

  function automatic logic [BL-1:0] rand_pins();
    logic [95:0] r;
    r = {$urandom, $urandom, $urandom};
    return r[BL-1:0];
  endfunction

  initial begin
    #(TCK_PERIOD * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]   cap;
    logic [127:0] din, dout;
    void'($urandom(32'd4242));
    por_n = 1'b0; tms = 1'b1; tdi = 1'b0; pins = '0;
    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    // R1: reset state
    check("R1 tdo_en", tdo_en, 0);
    check("R1 io_float", io_float, 0);
    check("R1 tdo", tdo, 0);
    por_n = 1'b1;
    repeat (3) step(1, 0);
    step(0, 0);
    check("R11 idle enable", tdo_en, 0);

    // R3/R6: scan after reset returns the identification word
    din = {$urandom, $urandom, $urandom, $urandom};
    scan_dr(din, dout);
    check("R3 R6 id after reset", dout[SCAN_N-1:0], exp_scan(3'b001, pins, din));

    // R11: falling-edge timing; bit0 of id is 1, bit1 is 0
    step(1, 0); step(0, 0); step(0, 0);
    check("R11 enable in shift", tdo_en, 1);
    check("R11 bit0", last_tdo, 1);
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    check("R11 holds past rising edge", tdo, 1);
    @(negedge tck); #1;
    check("R11 changes on falling edge", tdo, 0);
    step(1, 0); step(1, 0); step(0, 0);

    // R4/R10/R8: float-sample opcode, internal cell forced
    load_ir(3'b010, cap);
    check("R4 capture pattern", cap, 3'b001);
    check("R10 float on 010", io_float, 1);
    pins = '1;
    din = '0;
    scan_dr(din, dout);
    check("R8 chain with cell 50 const", dout[SCAN_N-1:0], exp_scan(3'b010, pins, din));

    // R9: shifted-in data does not reach next capture
    pins = rand_pins();
    din = {$urandom, $urandom, $urandom, $urandom};
    scan_dr('1, dout);
    scan_dr(din, dout);
    check("R9 observe only", dout[SCAN_N-1:0], exp_scan(3'b010, pins, din));

    // R10: sample/preload clears float request
    load_ir(3'b100, cap);
    check("R10 float off 100", io_float, 0);

    // R7/R5: bypass and unlisted codes
    for (int k = 0; k < 4; k++) begin
      logic [2:0] op;
      op = (k == 0) ? 3'b111 : (k == 1) ? 3'b011 : (k == 2) ? 3'b101 : 3'b110;
      load_ir(op, cap);
      din = {$urandom, $urandom, $urandom, $urandom};
      scan_dr(din, dout);
      check("R5 R7 bypass decode", dout[SCAN_N-1:0], exp_scan(op, pins, din));
    end

    // R2/R3: tms reset from Pause-DR with float instruction current
    load_ir(3'b010, cap);
    step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    tms_reset();
    check("R2 float cleared by tms reset", io_float, 0);
    din = {$urandom, $urandom, $urandom, $urandom};
    scan_dr(din, dout);
    check("R2 R3 id after tms reset", dout[SCAN_N-1:0], exp_scan(3'b001, pins, din));

    // R12/R5: random opcodes, pins and data, with random TMS walks
    for (int it = 0; it < 24; it++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      load_ir(op, cap);
      check("R4 capture random", cap, 3'b001);
      check("R10 float random", io_float, (op == 3'b010));
      pins = rand_pins();
      din = {$urandom, $urandom, $urandom, $urandom};
      scan_dr(din, dout);
      check("R12 R5 random scan", dout[SCAN_N-1:0], exp_scan(op, pins, din));
      if (it % 4 == 3) begin
        int walk;
        walk = 1 + int'($urandom % 20);
        for (int w = 0; w < walk; w++) step(1'($urandom), 1'($urandom));
        tms_reset();
        check("R2 random walk reset", io_float, 0);
        check("R11 enable after reset", tdo_en, 0);
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule